// File: doc/BRIEF.md
# Multi-Lane SPI Transfer Engine

This block is an SPI master that drives several one-bit data lanes at once. All lanes share one chip select and one serial clock. Each lane carries whole 8-bit words of its own, so a lane count of N moves up to N independent words per word time. This is not a wide bus carrying the bits of one word. Every transfer picks one of three lane modes. Single uses logical lane 0 only and behaves like an ordinary one-lane master. Mirror copies one transmit word onto every lane. Stripe deals consecutive buffer words round-robin across the lanes and shifts them together.

Software-side logic starts a transfer with a mode, a read flag, a length in buffer words, a clock divider value and a lane map. It then feeds transmit words through a valid/ready stream. The engine gathers all the words one slot needs before it toggles the clock. One slot is one word time on the wire. When the read flag is set, the words captured in a slot come out on a receive stream in logical lane order. A request the engine cannot carry out is refused with a one-cycle error pulse, and the bus is never touched. The lane map lets a peripheral wired to any physical pin still be addressed as a given logical lane.

Top module: `mlane_spi_master`

## Requirements
- R1: Mode code 0 (single) is the only mode that needs no lane-sharing support. Only the pin chosen by logical lane 0 carries data, and every other `mosi_o` pin stays low. Each slot uses one transmit word. A read in this mode returns one receive word per slot, taken from that pin.
- R2: Mode code 1 (mirror) drives the same transmit word on every `mosi_o` pin in the same bit times. Each slot uses one transmit word.
- R3: A start in mirror mode with `rd_i` = 1 is refused. `err_o` pulses for one cycle, `busy_o` stays low, and chip select and clock do not move.
- R4: Mode code 2 (stripe) assigns buffer word k to logical lane k mod N. Slot s carries words s*N to s*N+N-1, and all lanes shift in the same bit times.
- R5: A start is refused in the manner of R3 when `len_i` is 0, or when the mode is stripe and `len_i` is not a whole multiple of N.
- R6: A stripe read delivers N receive words per slot, ordered from logical lane 0 upward. For example, 0x11 captured on lane 0 and 0x88 on lane 1 come out as 0x11 and then 0x88.
- R7: Words are shifted most significant bit first, in SPI mode 0. The clock idles low, `mosi_o` changes only on a falling edge, and `miso_i` is sampled on each rising edge. Each slot has exactly 8 rising edges. Sending 0x88 puts 1,0,0,0,1,0,0,0 on the wire in that order.
- R8: Field l of `lane_map_i` is bits [l*LIDX_W +: LIDX_W]. It names the physical pin of logical lane l, for both transmit and receive, and it must be a permutation of the pins.
- R9: Mode code 3 is invalid, and a start with it is refused in the manner of R3.
- R10: `cs_n_o` falls at least one half period before the first rising clock edge. It stays low across all slots of a transfer and rises once, after the last bit. `done_o` pulses for one cycle at that point, with `busy_o` low.
- R11: The engine accepts transmit words only while it is collecting a slot. It raises no clock edge for a slot until all of that slot's words (N in stripe, 1 otherwise) have been accepted.
- R12: Each clock half period lasts `half_div_i`+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| mode_i | input | 2 | Lane mode: 0 single, 1 mirror, 2 stripe, 3 invalid |
| rd_i | input | 1 | Capture and return receive words |
| len_i | input | LEN_W | Transfer length in buffer words |
| half_div_i | input | DIV_W | Clock half period minus one, in system cycles |
| lane_map_i | input | NUM_LANES*LIDX_W | Logical-to-physical lane map |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | One-cycle pulse on a refused start |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_data_i | input | WORD_W | Transmit word |
| tx_ready_o | output | 1 | Transmit word accepted when high with valid |
| rx_valid_o | output | 1 | Receive word valid (no backpressure) |
| rx_data_o | output | WORD_W | Receive word |
| sck_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | NUM_LANES | Per-pin transmit data |
| miso_i | input | NUM_LANES | Per-pin receive data |

## Verification
The bench sweeps every mode code with and without reads, both lane-map permutations of a two-lane build, lengths from zero to four words, and two divider settings. A behavioural peripheral puts a different arithmetic word pattern on each physical pin. Each pin's captured transmit words therefore show whether a fault lies in lane selection, remapping or word interleaving, and distinct per-pin receive patterns expose swapped or misordered receive words. Gapped transmit feeding separates correct slot gathering from an engine that starts clocking too early. The refused combinations confirm that errors leave the bus still.

// File: rtl/mlane_pkg.sv
// Shared encodings for the multi-lane SPI engine.
// Assumes: mode codes are fixed by the start interface; code 3 is invalid.
package mlane_pkg;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_MIRROR = 2'd1,
        LM_STRIPE = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_LO,
        S_HI,
        S_UNLOAD
    } xfer_state_e;

endpackage

// File: rtl/mlane_half_timer.sv
// Half-period timer: while run is high, pulses tick once every half_div+1
// cycles. Assumes half_div stays constant while run is high; when run is low
// the count is held at zero so the first half period is full length.
module mlane_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_div);

    // Count system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r12_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half_div));

endmodule

// File: rtl/mlane_slot_gather.sv
// Slot gatherer: collects the transmit words one slot needs (all lanes in
// stripe mode, one word otherwise) into a small buffer. Words land at
// increasing indices. Assumes need_all is stable while enable is high.
module mlane_slot_gather #(
    parameter int NUM_LANES = 2,
    parameter int WORD_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               enable,
    input  logic                               clear,
    input  logic                               need_all,
    input  logic                               in_valid,
    input  logic [WORD_W-1:0]                  in_data,
    output logic                               in_ready,
    output logic                               full,
    output logic [NUM_LANES-1:0][WORD_W-1:0]   words
);

    localparam int CNT_W = $clog2(NUM_LANES + 1);
    localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;

    assign need     = need_all ? CNT_W'(NUM_LANES) : CNT_W'(1);
    assign full     = (cnt == need);
    assign in_ready = enable && !full;

    // Store each accepted word at the next free slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            words <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (in_valid && in_ready) begin
            words[cnt[IDX_W-1:0]] <= in_data;
            cnt                   <= cnt + 1'b1;
        end
    end

    a_r11_fill_within_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clear) |=> (cnt == $past(cnt) + 1'b1) && (cnt <= need));

endmodule

// File: rtl/mlane_lane_router.sv
// Lane router: connects logical lanes to physical pins through the lane map.
// Transmit pins not claimed by an active logical lane are driven low; in
// single mode only logical lane 0 is active. Assumes the map is a
// permutation of the physical pins.
module mlane_lane_router #(
    parameter int NUM_LANES = 2,
    parameter int LIDX_W    = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               active,
    input  logic                               single_only,
    input  logic                               mirror_mode,
    input  logic [NUM_LANES-1:0][LIDX_W-1:0]   lane_map,
    input  logic [NUM_LANES-1:0]               log_tx,
    output logic [NUM_LANES-1:0]               log_rx,
    input  logic [NUM_LANES-1:0]               phy_miso,
    output logic [NUM_LANES-1:0]               phy_mosi
);

    for (genvar p = 0; p < NUM_LANES; p++) begin : g_phy
        logic drive;
        // Drive pin p from whichever active logical lane maps onto it.
        always_comb begin
            drive = 1'b0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (active && (!single_only || l == 0) && lane_map[l] == LIDX_W'(p)) begin
                    drive = drive | log_tx[l];
                end
            end
        end
        assign phy_mosi[p] = drive;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_log
        logic sense;
        // Pick the receive pin that logical lane l is mapped onto.
        always_comb begin
            sense = 1'b0;
            for (int p = 0; p < NUM_LANES; p++) begin
                if (lane_map[l] == LIDX_W'(p)) begin
                    sense = phy_miso[p];
                end
            end
        end
        assign log_rx[l] = sense;
    end

    a_r1_single_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (active && single_only) |->
            ((phy_mosi & ~(NUM_LANES'(1) << lane_map[0])) == '0));

    a_r2_mirror_all_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mirror_mode) |-> (phy_mosi == '0 || phy_mosi == '1));

endmodule

// File: rtl/mlane_spi_master.sv
// Multi-lane SPI master, mode 0, MSB first. It checks and latches a transfer
// request, gathers one slot of transmit words, shifts every active lane for
// one word time, optionally returns the captured words in logical lane order,
// and repeats until all slots are sent. Assumes the lane map is a permutation
// and that the receive consumer takes one word per cycle (no backpressure).
module mlane_spi_master #(
    parameter int NUM_LANES = 2,
    parameter int WORD_W    = 8,
    parameter int DIV_W     = 8,
    parameter int LEN_W     = 8,
    localparam int LIDX_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [1:0]                    mode_i,
    input  logic                          rd_i,
    input  logic [LEN_W-1:0]              len_i,
    input  logic [DIV_W-1:0]              half_div_i,
    input  logic [NUM_LANES*LIDX_W-1:0]   lane_map_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          err_o,
    input  logic                          tx_valid_i,
    input  logic [WORD_W-1:0]             tx_data_i,
    output logic                          tx_ready_o,
    output logic                          rx_valid_o,
    output logic [WORD_W-1:0]             rx_data_o,
    output logic                          sck_o,
    output logic                          cs_n_o,
    output logic [NUM_LANES-1:0]          mosi_o,
    input  logic [NUM_LANES-1:0]          miso_i
);

    import mlane_pkg::*;

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [LIDX_W-1:0] LAST_LANE = LIDX_W'(NUM_LANES - 1);
    localparam logic [LEN_W-1:0]  LANES_LEN = LEN_W'(NUM_LANES);

    xfer_state_e                       state;
    logic [1:0]                        mode_q;
    logic                              rd_q;
    logic [DIV_W-1:0]                  div_q;
    logic [NUM_LANES-1:0][LIDX_W-1:0]  map_q;
    logic [LEN_W-1:0]                  slots_left;
    logic [BIT_W-1:0]                  bit_cnt;
    logic [LIDX_W-1:0]                 ucnt;
    logic [NUM_LANES-1:0][WORD_W-1:0]  tx_sh;
    logic [NUM_LANES-1:0][WORD_W-1:0]  rx_sh;
    logic [NUM_LANES-1:0][WORD_W-1:0]  slot_words;
    logic [NUM_LANES-1:0]              log_tx;
    logic [NUM_LANES-1:0]              log_rx;
    logic                              sck_q, cs_n_q, done_q, err_q;
    logic                              tick, slot_full, stripe_q, req_bad;
    logic [LEN_W-1:0]                  len_rem, slot_cnt;

    assign stripe_q = (mode_q == LM_STRIPE);

    // Validate a start request and derive its slot count.
    always_comb begin
        len_rem  = len_i % LANES_LEN;
        slot_cnt = (mode_i == LM_STRIPE) ? (len_i / LANES_LEN) : len_i;
        req_bad  = (len_i == '0)
                || (mode_i == 2'd3)
                || (mode_i == LM_MIRROR && rd_i)
                || (mode_i == LM_STRIPE && len_rem != '0);
    end

    mlane_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == S_LO || state == S_HI),
        .half_div (div_q),
        .tick     (tick)
    );

    mlane_slot_gather #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state == S_FILL),
        .clear    (state == S_IDLE || (state == S_FILL && slot_full)),
        .need_all (stripe_q),
        .in_valid (tx_valid_i),
        .in_data  (tx_data_i),
        .in_ready (tx_ready_o),
        .full     (slot_full),
        .words    (slot_words)
    );

    // Present the current MSB of each logical lane's shift register.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            log_tx[l] = tx_sh[l][WORD_W-1];
        end
    end

    mlane_lane_router #(.NUM_LANES(NUM_LANES), .LIDX_W(LIDX_W)) u_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (!cs_n_q),
        .single_only (mode_q == LM_SINGLE),
        .mirror_mode (mode_q == LM_MIRROR),
        .lane_map    (map_q),
        .log_tx      (log_tx),
        .log_rx      (log_rx),
        .phy_miso    (miso_i),
        .phy_mosi    (mosi_o)
    );

    // Transfer sequencer: accept, gather, shift, unload, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            mode_q     <= LM_SINGLE;
            rd_q       <= 1'b0;
            div_q      <= '0;
            map_q      <= '0;
            slots_left <= '0;
            bit_cnt    <= '0;
            ucnt       <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_i) begin
                        if (req_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            mode_q     <= mode_i;
                            rd_q       <= rd_i;
                            div_q      <= half_div_i;
                            map_q      <= lane_map_i;
                            slots_left <= slot_cnt;
                            state      <= S_FILL;
                        end
                    end
                end
                S_FILL: begin
                    if (slot_full) begin
                        for (int l = 0; l < NUM_LANES; l++) begin
                            if (stripe_q)                 tx_sh[l] <= slot_words[l];
                            else if (mode_q == LM_MIRROR) tx_sh[l] <= slot_words[0];
                            else if (l == 0)              tx_sh[l] <= slot_words[0];
                            else                          tx_sh[l] <= '0;
                        end
                        cs_n_q  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= S_LO;
                    end
                end
                S_LO: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        for (int l = 0; l < NUM_LANES; l++) begin
                            rx_sh[l] <= {rx_sh[l][WORD_W-2:0], log_rx[l]};
                        end
                        state <= S_HI;
                    end
                end
                S_HI: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        for (int l = 0; l < NUM_LANES; l++) begin
                            tx_sh[l] <= {tx_sh[l][WORD_W-2:0], 1'b0};
                        end
                        if (bit_cnt == LAST_BIT) begin
                            slots_left <= slots_left - 1'b1;
                            if (rd_q) begin
                                ucnt  <= '0;
                                state <= S_UNLOAD;
                            end else if (slots_left == LEN_W'(1)) begin
                                cs_n_q <= 1'b1;
                                done_q <= 1'b1;
                                state  <= S_IDLE;
                            end else begin
                                state <= S_FILL;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            state   <= S_LO;
                        end
                    end
                end
                S_UNLOAD: begin
                    ucnt <= ucnt + 1'b1;
                    if (!stripe_q || ucnt == LAST_LANE) begin
                        if (slots_left == '0) begin
                            cs_n_q <= 1'b1;
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            state <= S_FILL;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy_o     = (state != S_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign sck_o      = sck_q;
    assign cs_n_o     = cs_n_q;
    assign rx_valid_o = (state == S_UNLOAD);
    assign rx_data_o  = rx_sh[ucnt];

    a_r10_cs_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    a_r7_sck_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));

    a_r3_refusal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && cs_n_o && !sck_o));

    a_r11_no_clock_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> !sck_o);

    a_r10_done_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !busy_o && !sck_o));

    a_r1_one_word_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !stripe_q) |=> !rx_valid_o);

endmodule

// File: tb/mlane_spi_master_bench.sv
// Sweep bench for a two-lane build: every mode code, read flag, lane-map
// permutation, lengths 0..4 and two divider values, with expected words
// computed from the requirements.
module mlane_spi_master_bench;

    localparam int N  = 2;
    localparam int W  = 8;
    localparam int LW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          rd_i = 1'b0;
    logic [7:0]    len_i = '0;
    logic [7:0]    half_div_i = '0;
    logic [N*LW-1:0] lane_map_i = '0;
    logic          busy_o, done_o, err_o;
    logic          tx_valid_i = 1'b0;
    logic [W-1:0]  tx_data_i = '0;
    logic          tx_ready_o;
    logic          rx_valid_o;
    logic [W-1:0]  rx_data_o;
    logic          sck_o, cs_n_o;
    logic [N-1:0]  mosi_o;
    logic [N-1:0]  miso_i;

    always #10 clk = ~clk;

    mlane_spi_master #(.NUM_LANES(N), .WORD_W(W)) u_mlane_spi_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .rd_i(rd_i),
        .len_i(len_i), .half_div_i(half_div_i), .lane_map_i(lane_map_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
        .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int nrise, nfall, last_rise, cs_fall_at, cs_rises, words_sent, need_now, cur_div;
    int per_err, lead_err, order_err, rx_n;
    logic [7:0] cap_sh [N];
    logic [7:0] cap [N][8];
    logic [7:0] rx_got [16];

    function automatic logic [7:0] tw(input int i);
        return 8'h88 ^ 8'(i * 59);
    endfunction

    function automatic logic [7:0] pat(input int p, input int w);
        return ((p % 2 == 1) ? 8'h88 : 8'h11) ^ 8'(w * 91) ^ 8'((p / 2) * 60);
    endfunction

    function automatic logic pbit(input int p, input int n);
        logic [7:0] v;
        v = pat(p, n / 8);
        return v[7 - (n % 8)];
    endfunction

    always @(posedge clk) cyc = cyc + 1;

    // Behavioural peripheral: each pin presents its pattern, advancing on falls.
    always_comb begin
        for (int p = 0; p < N; p++) miso_i[p] = pbit(p, nfall);
    end

    always @(negedge sck_o) nfall = nfall + 1;
    always @(negedge cs_n_o) cs_fall_at = cyc;
    always @(posedge cs_n_o) cs_rises = cs_rises + 1;

    // Capture transmit pins on rising edges and check timing and gathering.
    always @(posedge sck_o) begin
        if (nrise % 8 == 0) begin
            if (nrise == 0 && (cyc - cs_fall_at) < cur_div + 1) lead_err = lead_err + 1;
        end else if (cyc - last_rise != 2 * (cur_div + 1)) begin
            per_err = per_err + 1;
        end
        last_rise = cyc;
        if (words_sent < (nrise / 8 + 1) * need_now) order_err = order_err + 1;
        for (int p = 0; p < N; p++) cap_sh[p] = {cap_sh[p][6:0], mosi_o[p]};
        nrise = nrise + 1;
        if (nrise % 8 == 0 && nrise <= 64) begin
            for (int p = 0; p < N; p++) cap[p][nrise / 8 - 1] = cap_sh[p];
        end
    end

    always @(negedge clk) begin
        if (rx_valid_o) begin
            if (rx_n < 16) rx_got[rx_n] = rx_data_o;
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input int mode, input bit rd, input int len, input int div,
                            input int m0, input int m1, input bit gap);
        bit    bad;
        int    slots, m[2], exp, lane;
        string rq;
        bad   = (len == 0) || (mode == 3) || (mode == 1 && rd) || (mode == 2 && (len % N) != 0);
        slots = (mode == 2) ? len / N : len;
        m[0] = m0; m[1] = m1;
        need_now = (mode == 2) ? N : 1;
        cur_div = div; nrise = 0; nfall = 0; words_sent = 0; cs_rises = 0; rx_n = 0;
        per_err = 0; lead_err = 0; order_err = 0;
        for (int p = 0; p < N; p++) for (int s = 0; s < 8; s++) cap[p][s] = 8'h00;
        @(negedge clk);
        mode_i = 2'(mode); rd_i = rd; len_i = 8'(len); half_div_i = 8'(div);
        lane_map_i = {1'(m1), 1'(m0)}; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (bad) begin
            rq = (mode == 3) ? "R9" : (mode == 1 && rd) ? "R3" : "R5";
            chk(err_o && !busy_o, rq, "refused start pulses err", {err_o, busy_o}, 2'b10);
            repeat (4) @(negedge clk);
            chk(cs_n_o && !tx_ready_o && nrise == 0 && !err_o, rq, "bus still after refusal",
                {cs_n_o, tx_ready_o, err_o}, 3'b100);
        end else begin
            chk(busy_o && !err_o, "R10", "busy after accepted start", {busy_o, err_o}, 2'b10);
            for (int i = 0; i < len; i++) begin
                bit acc;
                if (gap) repeat (i % 3) @(negedge clk);
                tx_valid_i = 1'b1; tx_data_i = tw(i);
                do begin
                    acc = tx_ready_o;
                    @(negedge clk);
                end while (!acc);
                tx_valid_i = 1'b0;
                words_sent = words_sent + 1;
            end
            while (!done_o) @(negedge clk);
            chk(cs_n_o && !busy_o && cs_rises == 1, "R10", "cs released once at done",
                cs_rises, 1);
            chk(lead_err == 0, "R10", "cs lead before first edge", lead_err, 0);
            chk(per_err == 0, "R12", "half period length", per_err, 0);
            chk(order_err == 0, "R11", "edge before slot gathered", order_err, 0);
            chk(nrise == slots * 8, "R7", "rising edges per transfer", nrise, slots * 8);
            for (int s = 0; s < slots; s++) begin
                for (int p = 0; p < N; p++) begin
                    if (mode == 0) begin
                        exp = (p == m[0]) ? int'(tw(s)) : 0;
                        rq  = "R1";
                    end else if (mode == 1) begin
                        exp = int'(tw(s));
                        rq  = "R2";
                    end else begin
                        lane = (m[0] == p) ? 0 : 1;
                        exp  = int'(tw(s * N + lane));
                        rq   = "R4";
                    end
                    if (m0 != 0) rq = {rq, "/R8"};
                    if (s == 0 && mode == 0) rq = {rq, "/R7"};
                    chk(int'(cap[p][s]) == exp, rq, $sformatf("tx pin %0d slot %0d", p, s),
                        cap[p][s], exp);
                end
            end
            exp = rd ? ((mode == 2) ? len : slots) : 0;
            chk(rx_n == exp, rd && mode == 2 ? "R6" : "R1", "receive word count", rx_n, exp);
            if (rd) begin
                for (int k = 0; k < exp && k < 16; k++) begin
                    int want;
                    if (mode == 2) want = int'(pat(m[k % N], k / N));
                    else           want = int'(pat(m[0], k));
                    rq = (mode == 2) ? "R6" : "R1";
                    if (m0 != 0) rq = {rq, "/R8"};
                    chk(int'(rx_got[k]) == want, rq, $sformatf("rx word %0d", k), rx_got[k], want);
                end
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o && !sck_o && !busy_o && !tx_ready_o && !rx_valid_o && mosi_o == '0,
            "R10", "reset state", {cs_n_o, sck_o, busy_o, tx_ready_o, mosi_o}, 5'b10000);
        // Example single write of 0x88 on logical lane 0, MSB first (R7).
        run_xfer(0, 1'b0, 1, 0, 0, 1, 1'b0);
        // Stripe read returning 0x11 then 0x88 (R6).
        run_xfer(2, 1'b1, 2, 1, 0, 1, 1'b0);
        for (int mode = 0; mode < 4; mode++)
            for (int rd = 0; rd < 2; rd++)
                for (int mp = 0; mp < 2; mp++)
                    for (int len = 0; len <= 4; len++)
                        for (int dv = 0; dv < 2; dv++)
                            run_xfer(mode, 1'(rd), len, dv * 2, mp, 1 - mp, 1'(len % 2));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule